// File: doc/BRIEF.md
# Power Gating Controller Register Block

This block switches the supply of up to sixteen peripheral power domains on and off under software control. Software talks to it over a simple register bus: a write strobe with address and write data, and a combinational read-data return. For each domain the block drives a power-switch output and watches a power-ready input coming back from the switch. It also holds the active-low isolation requests for a set of bus bridges and reflects their active-low acknowledges, so software can drain a bridge before it removes a domain's power.

Software first enables a domain in the mapping register. It then sets that domain's bit in the power-up or power-down request register and polls until the bit reads back as zero. A power-down only removes power while the domain's power-control-enable bit is set. A pair of neighbouring domains can be built as one twin domain: its mapping bits, request bits, power switches and completion always move together.

Top module: `pwr_gate_ctrl`

## Requirements
- R1: After reset the mapping, request, control and bridge-request registers all read 0, every power switch output is 0 and every bridge request output is 0.
- R2: The mapping register at offset 0x0EC holds bit n for domain n. A request written for a domain whose mapping bit is 0 is dropped: its request bit stays 0 and its switch does not move.
- R3: Writing 1 to bit n of the power-up request register (0x0F8) or the power-down request register (0x104) starts that domain's sequence. The bit reads 1 until the sequence ends and then clears by itself.
- R4: A power-up turns the switch on in the cycle after the write and completes only once power-ready has been high on 4 consecutive clock edges. A low cycle restarts the count.
- R5: A power-down turns the switch off only when bit 0 of the domain's control register is 1. With that bit 0 the request clears after one cycle and the switch stays on.
- R6: A power-down that turned the switch off completes on the first clock edge at which power-ready is low.
- R7: A request for a domain already in the requested state reads 1 for exactly one cycle and then clears, with no change on the switch.
- R8: Zero bits written to either request register have no effect on a sequence that is in progress.
- R9: Domain n has a control register at 0x800 + n*0x40 (bit 0 is the power-control enable, read/write) and a read-only status register 0x0C above it (bit 0 is the switch state, bit 1 is set once power-up has completed).
- R10: The handshake register at 0x1FC holds the bridge request bits at positions 5 to 11; they drive the active-low bridge request outputs directly. Positions 23 to 29 read the active-low acknowledge inputs.
- R11: Domains 8 and 9 form a twin. Setting or clearing either of their bits in the mapping or request registers acts on both. Their switches always match, and both request bits clear on the same edge once both domains are ready.
- R12: Reads of offsets that hold no register return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 12 | Byte address of the register access |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_rdata | output | 32 | Read data for bus_addr |
| pwr_sw | output | 16 | Per-domain power switch enable |
| pwr_ready | input | 16 | Per-domain power-good feedback |
| br_req_n | output | 7 | Bridge power-down requests, active low |
| br_ack_n | input | 7 | Bridge power-down acknowledges, active low |

## Verification
The bench builds the block with its default parameters: sixteen domains, a ready-count of four, seven bridges and domains 8 and 9 twinned. These values give an exact cycle count of seven edges from a power-up write to its completion and three edges for a gated power-down, so both are checked on the cycle. The twin case is reached with one half held not ready while the other has long since counted out. A bench power-ready model with per-domain hold-low controls lets a ready glitch be placed mid-count, which restarts the count, and keeps a sequence open while zero writes are issued against it.

// File: rtl/pgc_pkg.sv
package pgc_pkg;
  // Register offsets (byte addresses)
  localparam int OFF_MAP      = 'h0EC;
  localparam int OFF_PUP      = 'h0F8;
  localparam int OFF_PDN      = 'h104;
  localparam int OFF_HSK      = 'h1FC;
  localparam int DOM_BASE     = 'h800;
  localparam int DOM_STRIDE   = 'h40;
  localparam int DOM_STAT_OFS = 'h0C;

  typedef enum logic [1:0] {
    DS_OFF     = 2'd0,
    DS_RAMP_UP = 2'd1,
    DS_ON      = 2'd2,
    DS_RAMP_DN = 2'd3
  } dom_state_e;
endpackage

// File: rtl/pgc_rst_sync.sv
module pgc_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= 2'b00;
    else           sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_out = sync_q[1];
endmodule

// File: rtl/pgc_domain.sv
module pgc_domain import pgc_pkg::*; #(
  parameter int READY_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_up,
  input  logic start_dn,
  input  logic pcr,
  input  logic pwr_ready,
  input  logic fin_go,
  output logic sw_on,
  output logic is_on,
  output logic pend_up,
  output logic pend_dn,
  output logic fin_ok
);
  localparam int CNT_W = $clog2(READY_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(READY_CYCLES);

  dom_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             pu_q, pu_d, pd_q, pd_d;

  // Local completion condition; the twin partner may still hold it back.
  always_comb begin
    if (pu_q)
      fin_ok = (state_q == DS_ON) || (state_q == DS_RAMP_UP && cnt_q == CNT_FULL);
    else if (pd_q)
      fin_ok = (state_q == DS_OFF) || (state_q == DS_ON) ||
               (state_q == DS_RAMP_DN && !pwr_ready);
    else
      fin_ok = 1'b0;
  end

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    pu_d    = pu_q;
    pd_d    = pd_q;
    if (state_q == DS_RAMP_UP) begin
      if (!pwr_ready)            cnt_d = '0;
      else if (cnt_q != CNT_FULL) cnt_d = cnt_q + 1'b1;
    end
    if (start_up) begin
      pu_d = 1'b1;
      if (state_q == DS_OFF) begin
        state_d = DS_RAMP_UP;
        cnt_d   = '0;
      end
    end else if (start_dn) begin
      pd_d = 1'b1;
      if (state_q == DS_ON && pcr) state_d = DS_RAMP_DN;
    end else if (fin_go) begin
      pu_d = 1'b0;
      pd_d = 1'b0;
      if (state_q == DS_RAMP_UP) state_d = DS_ON;
      if (state_q == DS_RAMP_DN) state_d = DS_OFF;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= DS_OFF;
      cnt_q   <= '0;
      pu_q    <= 1'b0;
      pd_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      pu_q    <= pu_d;
      pd_q    <= pd_d;
    end
  end

  assign sw_on   = (state_q == DS_RAMP_UP) || (state_q == DS_ON);
  assign is_on   = (state_q == DS_ON);
  assign pend_up = pu_q;
  assign pend_dn = pd_q;
endmodule

// File: rtl/pwr_gate_ctrl.sv
module pwr_gate_ctrl import pgc_pkg::*; #(
  parameter int          NUM_DOM      = 16,
  parameter int          ADDR_W       = 12,
  parameter int          DATA_W       = 32,
  parameter int          READY_CYCLES = 4,
  parameter int          NUM_BR       = 7,
  parameter int          BR_REQ_LSB   = 5,
  parameter int          BR_ACK_LSB   = 23,
  parameter logic [15:0] TWIN_MASK    = 16'h0100
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  input  logic               bus_we,
  output logic [DATA_W-1:0]  bus_rdata,
  output logic [NUM_DOM-1:0] pwr_sw,
  input  logic [NUM_DOM-1:0] pwr_ready,
  output logic [NUM_BR-1:0]  br_req_n,
  input  logic [NUM_BR-1:0]  br_ack_n
);
  localparam logic [NUM_DOM-1:0] TWIN  = TWIN_MASK[NUM_DOM-1:0];
  localparam int                 IDX_W = 4;
  localparam int                 DOM_END = DOM_BASE + NUM_DOM * DOM_STRIDE;

  // A twin's low bit drags its upper partner along and vice versa.
  function automatic logic [NUM_DOM-1:0] gang(input logic [NUM_DOM-1:0] v);
    return v | ((v & TWIN) << 1) | ((v >> 1) & TWIN);
  endfunction

  logic               rst_q;
  logic [NUM_DOM-1:0] map_q, map_d, pcr_q, pcr_d, pcr_eff;
  logic [NUM_BR-1:0]  hsk_q, hsk_d;
  logic [NUM_DOM-1:0] pup_pend, pdn_pend, dom_on, fin_ok, fin_go;
  logic [NUM_DOM-1:0] start_up, start_dn, busy, wr_bits;
  logic               wr_map, wr_pup, wr_pdn, wr_hsk, wr_ctrl, in_dom;
  logic [ADDR_W-1:0]  dom_ofs;
  logic [IDX_W-1:0]   dom_idx;
  logic [5:0]         dom_sub;

  pgc_rst_sync u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_q)
  );

  // Address decode and next-state for the software registers
  always_comb begin
    dom_ofs  = bus_addr - ADDR_W'(DOM_BASE);
    dom_idx  = dom_ofs[6 +: IDX_W];
    dom_sub  = dom_ofs[5:0];
    in_dom   = (bus_addr >= ADDR_W'(DOM_BASE)) && (bus_addr < ADDR_W'(DOM_END));
    wr_map   = bus_we && (bus_addr == ADDR_W'(OFF_MAP));
    wr_pup   = bus_we && (bus_addr == ADDR_W'(OFF_PUP));
    wr_pdn   = bus_we && (bus_addr == ADDR_W'(OFF_PDN));
    wr_hsk   = bus_we && (bus_addr == ADDR_W'(OFF_HSK));
    wr_ctrl  = bus_we && in_dom && (dom_sub == 6'd0);
    wr_bits  = gang(bus_wdata[NUM_DOM-1:0]);
    busy     = pup_pend | pdn_pend;
    start_up = (wr_pup ? wr_bits : '0) & map_q & ~busy;
    start_dn = (wr_pdn ? wr_bits : '0) & map_q & ~busy;
    map_d    = wr_bits;
    pcr_d    = pcr_q;
    pcr_d[dom_idx] = bus_wdata[0];
    hsk_d    = bus_wdata[BR_REQ_LSB +: NUM_BR];
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      map_q <= '0;
      pcr_q <= '0;
      hsk_q <= '0;
    end else begin
      if (wr_map)  map_q <= map_d;
      if (wr_ctrl) pcr_q <= pcr_d;
      if (wr_hsk)  hsk_q <= hsk_d;
    end
  end

  assign br_req_n = hsk_q;

  // Per-domain sequencers, with twin coupling chosen per position
  for (genvar d = 0; d < NUM_DOM; d++) begin : g_dom
    localparam bit IS_LO = (d < NUM_DOM - 1) ? TWIN[d] : 1'b0;
    localparam bit IS_HI = (d > 0) ? TWIN[(d > 0) ? d - 1 : 0] : 1'b0;

    if (IS_LO) begin : g_lo
      assign fin_go[d]  = fin_ok[d] & fin_ok[d+1];
      assign pcr_eff[d] = pcr_q[d];
    end else if (IS_HI) begin : g_hi
      assign fin_go[d]  = fin_ok[d] & fin_ok[d-1];
      assign pcr_eff[d] = pcr_q[d-1];
    end else begin : g_solo
      assign fin_go[d]  = fin_ok[d];
      assign pcr_eff[d] = pcr_q[d];
    end

    pgc_domain #(.READY_CYCLES(READY_CYCLES)) u_dom (
      .clk       (clk),
      .rst_n     (rst_q),
      .start_up  (start_up[d]),
      .start_dn  (start_dn[d]),
      .pcr       (pcr_eff[d]),
      .pwr_ready (pwr_ready[d]),
      .fin_go    (fin_go[d]),
      .sw_on     (pwr_sw[d]),
      .is_on     (dom_on[d]),
      .pend_up   (pup_pend[d]),
      .pend_dn   (pdn_pend[d]),
      .fin_ok    (fin_ok[d])
    );
  end

  // Read return
  always_comb begin
    bus_rdata = '0;
    if (bus_addr == ADDR_W'(OFF_MAP)) begin
      bus_rdata[NUM_DOM-1:0] = map_q;
    end else if (bus_addr == ADDR_W'(OFF_PUP)) begin
      bus_rdata[NUM_DOM-1:0] = pup_pend;
    end else if (bus_addr == ADDR_W'(OFF_PDN)) begin
      bus_rdata[NUM_DOM-1:0] = pdn_pend;
    end else if (bus_addr == ADDR_W'(OFF_HSK)) begin
      bus_rdata[BR_REQ_LSB +: NUM_BR] = hsk_q;
      bus_rdata[BR_ACK_LSB +: NUM_BR] = br_ack_n;
    end else if (in_dom) begin
      if (dom_sub == 6'd0)
        bus_rdata[0] = pcr_q[dom_idx];
      else if (dom_sub == 6'(DOM_STAT_OFS))
        bus_rdata[1:0] = {dom_on[dom_idx], pwr_sw[dom_idx]};
    end
  end
endmodule

// File: rtl/pwr_gate_ctrl_chk.sv
module pwr_gate_ctrl_chk import pgc_pkg::*; #(
  parameter int                 NUM_DOM = 16,
  parameter int                 ADDR_W  = 12,
  parameter int                 NUM_BR  = 7,
  parameter logic [NUM_DOM-1:0] TWIN    = '0
) (
  input logic               clk,
  input logic               rst_n,
  input logic               bus_we,
  input logic [ADDR_W-1:0]  bus_addr,
  input logic [NUM_DOM-1:0] pup_pend,
  input logic [NUM_DOM-1:0] map_q,
  input logic [NUM_DOM-1:0] pcr_eff,
  input logic [NUM_DOM-1:0] pwr_sw,
  input logic [NUM_DOM-1:0] pwr_ready,
  input logic [NUM_BR-1:0]  br_req_n
);
  AST_SW_ON_NEEDS_MAP: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_sw & ~$past(pwr_sw) & ~$past(map_q)) == '0); // R2

  AST_PUP_SET_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    ((pup_pend & ~$past(pup_pend)) != '0) |-> $past(bus_we && bus_addr == ADDR_W'(OFF_PUP))); // R3

  AST_PUP_DONE_NEEDS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(pup_pend) & ~pup_pend & pwr_sw & ~$past(pwr_ready)) == '0); // R4

  AST_SW_OFF_NEEDS_PCR: assert property (@(posedge clk) disable iff (!rst_n)
    (~pwr_sw & $past(pwr_sw) & ~$past(pcr_eff)) == '0); // R5

  AST_BRIDGE_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(bus_we && bus_addr == ADDR_W'(OFF_HSK)) |-> $stable(br_req_n)); // R10

  AST_TWIN_SWITCH_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    ((pwr_sw ^ (pwr_sw >> 1)) & TWIN) == '0); // R11
endmodule

bind pwr_gate_ctrl pwr_gate_ctrl_chk #(
  .NUM_DOM (NUM_DOM),
  .ADDR_W  (ADDR_W),
  .NUM_BR  (NUM_BR),
  .TWIN    (TWIN)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_q),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .pup_pend  (pup_pend),
  .map_q     (map_q),
  .pcr_eff   (pcr_eff),
  .pwr_sw    (pwr_sw),
  .pwr_ready (pwr_ready),
  .br_req_n  (br_req_n)
);

// File: tb/pwr_gate_ctrl_test.sv
`timescale 1ns/1ps
module pwr_gate_ctrl_test;
  localparam logic [11:0] A_MAP = 12'h0EC;
  localparam logic [11:0] A_PUP = 12'h0F8;
  localparam logic [11:0] A_PDN = 12'h104;
  localparam logic [11:0] A_HSK = 12'h1FC;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [11:0] bus_addr;
  logic [31:0] bus_wdata;
  logic        bus_we;
  logic [31:0] bus_rdata;
  logic [15:0] pwr_sw;
  logic [15:0] pwr_ready;
  logic [6:0]  br_req_n;
  logic [6:0]  br_ack_n;

  logic [15:0] sw_d1 = '0, sw_d2 = '0, hold_low = '0;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  // Power-ready model: follows the switch two cycles late, can be held low
  always @(posedge clk) begin
    sw_d1 <= pwr_sw;
    sw_d2 <= sw_d1;
  end
  assign pwr_ready = sw_d2 & ~hold_low;

  pwr_gate_ctrl uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_we    (bus_we),
    .bus_rdata (bus_rdata),
    .pwr_sw    (pwr_sw),
    .pwr_ready (pwr_ready),
    .br_req_n  (br_req_n),
    .br_ack_n  (br_ack_n)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] v);
    bus_addr = a; bus_wdata = v; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] v);
    bus_addr = a; bus_we = 1'b0;
    #1 v = bus_rdata;
  endtask

  task automatic rd_chk(input string req, input logic [11:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(req, v, exp);
  endtask

  task automatic t_reset;
    rd_chk("R1 map", A_MAP, 0);
    rd_chk("R1 pup", A_PUP, 0);
    rd_chk("R1 pdn", A_PDN, 0);
    rd_chk("R1 hsk", A_HSK, 32'(br_ack_n) << 23);
    rd_chk("R1 ctrl0", 12'h800, 0);
    chk("R1 switches", 32'(pwr_sw), 0);
    chk("R1 bridge req", 32'(br_req_n), 0);
  endtask

  task automatic t_regs;
    wr(12'h800, 32'h1);
    rd_chk("R9 ctrl0 readback", 12'h800, 32'h1);
    rd_chk("R9 status0 off", 12'h80C, 32'h0);
    wr(A_MAP, 32'h0107);
    rd_chk("R11 map gang", A_MAP, 32'h0307);
    rd_chk("R12 hole 0x010", 12'h010, 0);
    rd_chk("R12 hole in dom", 12'h8C4, 0);
    rd_chk("R12 past last dom", 12'hC00, 0);
  endtask

  task automatic t_unmapped;
    wr(A_PUP, 32'h8);
    rd_chk("R2 unmapped pend", A_PUP, 0);
    repeat (8) @(negedge clk);
    chk("R2 unmapped switch", 32'(pwr_sw[3]), 0);
  endtask

  task automatic t_power_up;
    wr(A_PUP, 32'h1);
    rd_chk("R3 pend set", A_PUP, 32'h1);
    chk("R4 switch on next cycle", 32'(pwr_sw[0]), 1);
    repeat (6) @(negedge clk);
    rd_chk("R4 still pending at edge 6", A_PUP, 32'h1);
    @(negedge clk);
    rd_chk("R3 self clear at edge 7", A_PUP, 0);
    rd_chk("R9 status0 on", 12'h80C, 32'h3);
  endtask

  task automatic t_already_on;
    wr(A_PUP, 32'h1);
    rd_chk("R7 pend one cycle", A_PUP, 32'h1);
    @(negedge clk);
    rd_chk("R7 cleared", A_PUP, 0);
    chk("R7 switch unchanged", 32'(pwr_sw[0]), 1);
  endtask

  task automatic t_ready_glitch;
    hold_low[1] = 1'b1;
    wr(A_PUP, 32'h2);
    repeat (8) @(negedge clk);
    rd_chk("R4 waits for ready", A_PUP, 32'h2);
    hold_low[1] = 1'b0;
    repeat (3) @(negedge clk);
    hold_low[1] = 1'b1;
    repeat (2) @(negedge clk);
    hold_low[1] = 1'b0;
    repeat (4) @(negedge clk);
    rd_chk("R4 count restarted", A_PUP, 32'h2);
    @(negedge clk);
    rd_chk("R4 done after 4 fresh", A_PUP, 0);
  endtask

  task automatic t_pdn_gated;
    wr(A_PDN, 32'h2);
    rd_chk("R5 gated pend", A_PDN, 32'h2);
    @(negedge clk);
    rd_chk("R5 gated clear", A_PDN, 0);
    repeat (4) @(negedge clk);
    chk("R5 gated switch stays", 32'(pwr_sw[1]), 1);
  endtask

  task automatic t_pdn_real;
    wr(A_PDN, 32'h1);
    chk("R5 switch off", 32'(pwr_sw[0]), 0);
    repeat (2) @(negedge clk);
    rd_chk("R6 waits ready low", A_PDN, 32'h1);
    @(negedge clk);
    rd_chk("R6 done on ready low", A_PDN, 0);
    rd_chk("R9 status0 off again", 12'h80C, 0);
  endtask

  task automatic t_already_off;
    wr(A_PDN, 32'h1);
    rd_chk("R7 off pend one cycle", A_PDN, 32'h1);
    @(negedge clk);
    rd_chk("R7 off cleared", A_PDN, 0);
    chk("R7 off switch", 32'(pwr_sw[0]), 0);
  endtask

  task automatic t_zero_write;
    hold_low[2] = 1'b1;
    wr(A_PUP, 32'h4);
    repeat (3) @(negedge clk);
    wr(A_PUP, 32'h0);
    rd_chk("R8 pup zero ignored", A_PUP, 32'h4);
    wr(A_PDN, 32'h0);
    rd_chk("R8 pdn zero ignored", A_PDN, 0);
    chk("R8 switch kept", 32'(pwr_sw[2]), 1);
    hold_low[2] = 1'b0;
    repeat (6) @(negedge clk);
    rd_chk("R8 finishes", A_PUP, 0);
  endtask

  task automatic t_twin;
    hold_low[9] = 1'b1;
    wr(A_PUP, 32'h200);
    rd_chk("R11 both pending", A_PUP, 32'h300);
    chk("R11 both switches", 32'(pwr_sw[9:8]), 32'h3);
    repeat (10) @(negedge clk);
    rd_chk("R11 lo waits for hi", A_PUP, 32'h300);
    hold_low[9] = 1'b0;
    repeat (4) @(negedge clk);
    rd_chk("R11 still pending", A_PUP, 32'h300);
    @(negedge clk);
    rd_chk("R11 clear together", A_PUP, 0);
    rd_chk("R11 status8 on", 12'hA0C, 32'h3);
  endtask

  task automatic t_hsk;
    br_ack_n = 7'h55;
    wr(A_HSK, 32'h0000_0FE0);
    chk("R10 bridge outputs", 32'(br_req_n), 32'h7F);
    rd_chk("R10 hsk read", A_HSK, (32'h55 << 23) | 32'hFE0);
    wr(A_HSK, 32'h0000_0140);
    chk("R10 bridge partial", 32'(br_req_n), 32'h0A);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bus_addr = '0; bus_wdata = '0; bus_we = 1'b0; br_ack_n = 7'h2A;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset;
    t_regs;
    t_unmapped;
    t_power_up;
    t_already_on;
    t_ready_glitch;
    t_pdn_gated;
    t_pdn_real;
    t_already_off;
    t_zero_write;
    t_twin;
    t_hsk;
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule